// File: doc/BRIEF.md
# Serial-Row LED Panel Scan Controller

This block produces the pin-level waveforms for one row period of a HUB75-style RGB LED matrix. The matrix's column drivers need a latch strobe that lasts several clocks. Its rows are chosen by a shift register instead of a binary address decoder. For every row the block takes a parameterised number of two-pixel words from a valid/ready source. It presents each word on six RGB lines and strobes the pixel clock once per word. It holds the latch high over the final columns of the row.

Row selection uses three lines. Line A clocks the row shift register. Line B blanks the row drivers. Line C carries the serial token. A single token is inserted while row 0 is shifted, and every later row only pushes it one stage further. Output enable (active low) is released at the first column of a row and pulled back high for the latch and row-select columns. The block stalls with the pixel clock low whenever the source has no word ready.

Top module: `panel_row_scan`

## Requirements
- R1: While reset is applied and until the first word is accepted, `dclk_o`, `lat_o`, `row_a_o`, `row_b_o`, `row_c_o` and `rgb_o` are 0, `oe_n_o` is 1 and `row_o` is 0. Once reset has been released for a few cycles, `pix_ready_o` is 1.
- R2: When `pix_valid_i` and `pix_ready_o` are both high at a clock edge, the word appears on `rgb_o` in the next cycle. In that cycle `dclk_o` is 0 and `pix_ready_o` is 0. In the cycle after it, `dclk_o` is 1 for exactly one cycle and `rgb_o` is unchanged. The bit order is bit 5 red upper, bit 4 green upper, bit 3 blue upper, bit 2 red lower, bit 1 green lower, bit 0 blue lower.
- R3: While `pix_valid_i` is low and the block is ready, `dclk_o` stays 0, `rgb_o` holds, and no column is consumed.
- R4: `lat_o` is 1 during the slots of the last LATCH_LEN columns of each row (default: columns WIDTH-3, WIDTH-2 and WIDTH-1). It is 0 during all other column slots.
- R5: `row_c_o` is 1 during the slots of columns WIDTH-2 and WIDTH-1, and only while `row_o` is 0. It is 0 in every other row.
- R6: `row_a_o` and `row_b_o` are 1 together during the slot of column WIDTH-1 of every row, and 0 during every other slot.
- R7: `oe_n_o` is 1 from the first latch slot of a row until the slot of column 0 of the next row, where it becomes 0.
- R8: One cycle after the pixel clock pulse of column WIDTH-1, `lat_o`, `row_a_o`, `row_b_o` and `row_c_o` return to 0 and `oe_n_o` stays 1, even if no new word arrives.
- R9: `row_o` advances by one in that same cycle, after WIDTH accepted words, and wraps from ROWS-1 to 0.

Verification is split by requirement: the assertions check timing properties cycle by cycle, and the bench checks values, token placement and row progression end to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | Source has a two-pixel word |
| pix_data_i | input | 6 | Two-pixel word, bit order per R2 |
| pix_ready_o | output | 1 | Block accepts a word this cycle |
| row_o | output | $clog2(ROWS) | Row currently being shifted |
| dclk_o | output | 1 | Column pixel clock |
| rgb_o | output | 6 | Column data, bit order per R2 |
| lat_o | output | 1 | Column driver latch |
| oe_n_o | output | 1 | Output enable, active low |
| row_a_o | output | 1 | Row shift clock |
| row_b_o | output | 1 | Row blanking |
| row_c_o | output | 1 | Row serial token |

## Verification
Each row is fed with a source validity rate chosen by the row number modulo four: always valid, half, ninety percent and twenty percent.

The always-valid rows test back-to-back handshakes at the maximum rate. A sparse row makes stalls fall at the row end, which separates the line release of R8 from a release caused by the next accepted word. Two full frames are run, so the wrap and the re-insertion of the token on row 0 are observed twice. Every output is compared on every cycle against a model built from column and row counts alone.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic {
    PH_SETUP  = 1'b0,
    PH_STROBE = 1'b1
  } lrs_phase_e;

  typedef struct packed {
    logic r_up;
    logic g_up;
    logic b_up;
    logic r_dn;
    logic g_dn;
    logic b_dn;
  } lrs_rgb_t;

  typedef struct packed {
    logic lat;
    logic oe_n;
    logic a;
    logic b;
    logic c;
  } lrs_lines_t;

endpackage

// File: rtl/lrs_rst_sync.sv
module lrs_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/lrs_col_timer.sv
module lrs_col_timer
  import lrs_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int COL_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             take_o,
  output logic [COL_W-1:0] col_o,
  output logic             dclk_o,
  output logic             row_end_o
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(WIDTH - 1);

  lrs_phase_e       phase_q, phase_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             col_en;
  logic             dclk_q, dclk_d;
  logic             last_col;

  assign last_col = (col_q == LAST_COL);
  assign ready_o  = (phase_q == PH_SETUP);
  assign take_o   = ready_o && valid_i;
  assign col_en   = (phase_q == PH_STROBE);

  always_comb begin
    phase_d = phase_q;
    col_d   = col_q;
    dclk_d  = 1'b0;
    unique case (phase_q)
      PH_SETUP: begin
        if (take_o) begin
          phase_d = PH_STROBE;
        end
      end
      PH_STROBE: begin
        phase_d = PH_SETUP;
        dclk_d  = 1'b1;
        col_d   = last_col ? '0 : col_q + 1'b1;
      end
      default: phase_d = PH_SETUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SETUP;
      dclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      dclk_q  <= dclk_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
    end else if (col_en) begin
      col_q <= col_d;
    end
  end

  assign col_o     = col_q;
  assign dclk_o    = dclk_q;
  assign row_end_o = (phase_q == PH_STROBE) && last_col;

endmodule

// File: rtl/lrs_row_counter.sv
module lrs_row_counter #(
  parameter int ROWS  = 32,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o,
  output logic             first_o
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
    end else if (step_i) begin
      row_q <= row_d;
    end
  end

  assign row_o   = row_q;
  assign first_o = (row_q == '0);

endmodule

// File: rtl/lrs_line_ctrl.sv
module lrs_line_ctrl
  import lrs_pkg::*;
#(
  parameter int WIDTH     = 64,
  parameter int LATCH_LEN = 3,
  parameter int COL_W     = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             first_row_i,
  input  lrs_rgb_t         pix_i,
  input  logic             row_end_i,
  output lrs_rgb_t         rgb_o,
  output lrs_lines_t       lines_o,
  output logic             row_done_o
);

  localparam logic [COL_W-1:0] LAT_FROM = COL_W'(WIDTH - LATCH_LEN);
  localparam logic [COL_W-1:0] TOK_FROM = COL_W'(WIDTH - 2);
  localparam logic [COL_W-1:0] SEL_COL  = COL_W'(WIDTH - 1);

  localparam lrs_lines_t LINES_IDLE = '{lat: 1'b0, oe_n: 1'b1, a: 1'b0, b: 1'b0, c: 1'b0};

  lrs_rgb_t   rgb_q;
  lrs_lines_t lines_q, lines_d, slot_lines;
  logic       lines_en;
  logic       done_q;

  // Line levels that belong to the column slot being accepted now.
  always_comb begin
    slot_lines.lat  = (col_i >= LAT_FROM);
    slot_lines.oe_n = (col_i >= LAT_FROM);
    slot_lines.a    = (col_i == SEL_COL);
    slot_lines.b    = (col_i == SEL_COL);
    slot_lines.c    = first_row_i && (col_i >= TOK_FROM);
  end

  assign lines_en = take_i || done_q;

  always_comb begin
    if (take_i) begin
      lines_d = slot_lines;
    end else begin
      lines_d = LINES_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_q <= '0;
    end else if (take_i) begin
      rgb_q <= pix_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q <= LINES_IDLE;
    end else if (lines_en) begin
      lines_q <= lines_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
    end else begin
      done_q <= row_end_i;
    end
  end

  assign rgb_o      = rgb_q;
  assign lines_o    = lines_q;
  assign row_done_o = done_q;

endmodule

// File: rtl/panel_row_scan.sv
module panel_row_scan
  import lrs_pkg::*;
#(
  parameter int WIDTH     = 64,
  parameter int ROWS      = 32,
  parameter int LATCH_LEN = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pix_valid_i,
  input  logic [5:0]              pix_data_i,
  output logic                    pix_ready_o,
  output logic [$clog2(ROWS)-1:0] row_o,
  output logic                    dclk_o,
  output logic [5:0]              rgb_o,
  output logic                    lat_o,
  output logic                    oe_n_o,
  output logic                    row_a_o,
  output logic                    row_b_o,
  output logic                    row_c_o
);

  localparam int COL_W = $clog2(WIDTH);
  localparam int ROW_W = $clog2(ROWS);

  logic             rst_sync_n;
  logic             take;
  logic             row_end;
  logic             row_done;
  logic             first_row;
  logic [COL_W-1:0] col;
  lrs_rgb_t         pix_s, rgb_s;
  lrs_lines_t       lines_s;

  assign pix_s = lrs_rgb_t'(pix_data_i);

  lrs_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  lrs_col_timer #(.WIDTH(WIDTH), .COL_W(COL_W)) u_col (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .valid_i   (pix_valid_i),
    .ready_o   (pix_ready_o),
    .take_o    (take),
    .col_o     (col),
    .dclk_o    (dclk_o),
    .row_end_o (row_end)
  );

  lrs_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .step_i  (row_done),
    .row_o   (row_o),
    .first_o (first_row)
  );

  lrs_line_ctrl #(.WIDTH(WIDTH), .LATCH_LEN(LATCH_LEN), .COL_W(COL_W)) u_lines (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .take_i      (take),
    .col_i       (col),
    .first_row_i (first_row),
    .pix_i       (pix_s),
    .row_end_i   (row_end),
    .rgb_o       (rgb_s),
    .lines_o     (lines_s),
    .row_done_o  (row_done)
  );

  assign rgb_o   = rgb_s;
  assign lat_o   = lines_s.lat;
  assign oe_n_o  = lines_s.oe_n;
  assign row_a_o = lines_s.a;
  assign row_b_o = lines_s.b;
  assign row_c_o = lines_s.c;

endmodule

// File: rtl/panel_row_scan_chk.sv
module panel_row_scan_chk #(
  parameter int ROWS = 32
) (
  input logic                    clk_i,
  input logic                    rst_sync_ni,
  input logic                    pix_valid_i,
  input logic                    pix_ready_o,
  input logic                    dclk_o,
  input logic [5:0]              rgb_o,
  input logic                    lat_o,
  input logic                    oe_n_o,
  input logic                    row_a_o,
  input logic                    row_b_o,
  input logic                    row_c_o,
  input logic [$clog2(ROWS)-1:0] row_o
);

  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  // R2: an accepted word is presented with the pixel clock low, ready withdrawn
  a_r2_accept_setup: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (pix_valid_i && pix_ready_o) |=> (!dclk_o && !pix_ready_o));

  // R2: the setup cycle is followed by one clock-high cycle with data held
  a_r2_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (!pix_ready_o) |=> (dclk_o && pix_ready_o && $stable(rgb_o)));

  // R2: the pixel clock is never high for two cycles in a row
  a_r2_single_high: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    dclk_o |=> !dclk_o);

  // R3: without a valid word nothing is clocked and data holds
  a_r3_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (pix_ready_o && !pix_valid_i) |=> (!dclk_o && $stable(rgb_o)));

  // R4 / R6: the row-select pulse lies inside the latch window, A and B together
  a_r6_select_in_latch: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    row_a_o |-> (lat_o && row_b_o));

  // R5: the token goes with the select pulse on row 0 only
  a_r5_token_row0: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (row_a_o && !dclk_o) |-> (row_c_o == (row_o == '0)));

  // R7: display blanked whenever the latch is high
  a_r7_blank_on_latch: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    lat_o |-> oe_n_o);

  // R8: lines released one cycle after the final pixel clock of a row
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (row_a_o && dclk_o) |=> (!row_a_o && !row_b_o && !row_c_o && !lat_o));

  // R9: row moves only after the row-end clock and wraps at the last row
  a_r9_row_step: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (row_o != $past(row_o)) |->
      ($past(row_a_o && dclk_o) &&
       (row_o == (($past(row_o) == LAST_ROW) ? '0 : $past(row_o) + 1'b1))));

endmodule

bind panel_row_scan panel_row_scan_chk #(.ROWS(ROWS)) chk_i (
  .clk_i       (clk_i),
  .rst_sync_ni (rst_sync_n),
  .pix_valid_i (pix_valid_i),
  .pix_ready_o (pix_ready_o),
  .dclk_o      (dclk_o),
  .rgb_o       (rgb_o),
  .lat_o       (lat_o),
  .oe_n_o      (oe_n_o),
  .row_a_o     (row_a_o),
  .row_b_o     (row_b_o),
  .row_c_o     (row_c_o),
  .row_o       (row_o)
);

// File: tb/panel_row_scan_tb_top.sv
`timescale 1ns/1ps
module panel_row_scan_tb_top;

  localparam int W  = 64;
  localparam int R  = 32;
  localparam int LL = 3;
  localparam int RW = $clog2(R);

  localparam int ST_IDLE = 0;
  localparam int ST_SET  = 1;
  localparam int ST_HIGH = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          pix_valid_i;
  logic [5:0]    pix_data_i;
  logic          pix_ready_o;
  logic [RW-1:0] row_o;
  logic          dclk_o;
  logic [5:0]    rgb_o;
  logic          lat_o, oe_n_o, row_a_o, row_b_o, row_c_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  panel_row_scan #(.WIDTH(W), .ROWS(R), .LATCH_LEN(LL)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .pix_ready_o (pix_ready_o),
    .row_o       (row_o),
    .dclk_o      (dclk_o),
    .rgb_o       (rgb_o),
    .lat_o       (lat_o),
    .oe_n_o      (oe_n_o),
    .row_a_o     (row_a_o),
    .row_b_o     (row_b_o),
    .row_c_o     (row_c_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit f_lat(input int col);
    return col >= W - LL;
  endfunction
  function automatic bit f_tok(input int col, input int row);
    return (row == 0) && (col >= W - 2);
  endfunction
  function automatic bit f_sel(input int col);
    return col == W - 1;
  endfunction

  task automatic chk_lines(input string tag, input bit lat, input bit oe_n,
                           input bit ab, input bit c);
    chk({tag, " R4 lat"}, 32'(lat_o), 32'(lat));
    chk({tag, " R7 oe_n"}, 32'(oe_n_o), 32'(oe_n));
    chk({tag, " R6 a"}, 32'(row_a_o), 32'(ab));
    chk({tag, " R6 b"}, 32'(row_b_o), 32'(ab));
    chk({tag, " R5 c"}, 32'(row_c_o), 32'(c));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int st, m_col, m_row, frames, prob;
    bit was_last, row_moved, hs_prev;
    logic [5:0] pend_rgb, exp_rgb;
    bit e_lat, e_oe, e_ab, e_c;

    void'($urandom(32'h5EED_0042));
    rst_ni      = 1'b1;
    pix_valid_i = 1'b0;
    pix_data_i  = '0;
    #1 rst_ni = 1'b0;

    // R1: state under reset
    repeat (3) @(negedge clk_i);
    chk("R1 dclk in reset", 32'(dclk_o), 0);
    chk("R1 rgb in reset", 32'(rgb_o), 0);
    chk("R1 row in reset", 32'(row_o), 0);
    chk_lines("R1 reset", 1'b0, 1'b1, 1'b0, 1'b0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1 ready after release", 32'(pix_ready_o), 1);
    chk("R1 dclk after release", 32'(dclk_o), 0);
    chk_lines("R1 after release", 1'b0, 1'b1, 1'b0, 1'b0);

    st = ST_IDLE; m_col = 0; m_row = 0; frames = 0;
    was_last = 1'b0; row_moved = 1'b0; hs_prev = 1'b0;
    pend_rgb = '0; exp_rgb = '0;
    e_lat = 1'b0; e_oe = 1'b1; e_ab = 1'b0; e_c = 1'b0;

    while (frames < 2) begin
      // outputs are sampled here, after the preceding rising edge
      row_moved = 1'b0;
      if (st == ST_HIGH && was_last) begin
        m_row     = (m_row == R - 1) ? 0 : m_row + 1;
        row_moved = 1'b1;
        was_last  = 1'b0;
        if (m_row == 0) frames++;
      end

      if (hs_prev) begin
        exp_rgb = pend_rgb;
        e_lat = f_lat(m_col); e_oe = f_lat(m_col);
        e_ab  = f_sel(m_col); e_c  = f_tok(m_col, m_row);
        chk("R2 rgb after accept", 32'(rgb_o), 32'(exp_rgb));
        chk("R2 dclk low in setup", 32'(dclk_o), 0);
        chk("R2 ready low in setup", 32'(pix_ready_o), 0);
        chk("R9 row during slot", 32'(row_o), 32'(m_row));
        chk_lines("slot", e_lat, e_oe, e_ab, e_c);
        st = ST_SET;
      end else if (st == ST_SET) begin
        chk("R2 dclk high", 32'(dclk_o), 1);
        chk("R2 ready back", 32'(pix_ready_o), 1);
        chk("R2 rgb held on clock", 32'(rgb_o), 32'(exp_rgb));
        chk_lines("clock", e_lat, e_oe, e_ab, e_c);
        was_last = (m_col == W - 1);
        m_col    = (m_col == W - 1) ? 0 : m_col + 1;
        st = ST_HIGH;
      end else begin
        chk("R3 dclk low idle", 32'(dclk_o), 0);
        chk("R3 rgb held idle", 32'(rgb_o), 32'(exp_rgb));
        if (row_moved) begin
          e_lat = 1'b0; e_oe = 1'b1; e_ab = 1'b0; e_c = 1'b0;
          chk_lines("R8 release", e_lat, e_oe, e_ab, e_c);
          chk("R9 row advanced", 32'(row_o), 32'(m_row));
        end else begin
          chk_lines("R3 hold", e_lat, e_oe, e_ab, e_c);
        end
        st = ST_IDLE;
      end

      // drive the next cycle's inputs; validity rate depends on row
      case (m_row % 4)
        0:       prob = 100;
        1:       prob = 50;
        2:       prob = 90;
        default: prob = 20;
      endcase
      pix_valid_i = ($urandom_range(99) < prob);
      pix_data_i  = 6'($urandom);
      pend_rgb    = pix_data_i;
      hs_prev     = pix_valid_i && pix_ready_o;
      @(negedge clk_i);
    end

    pix_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R9 wrapped frames", 32'(frames), 2);
    finish_run();
  end

endmodule